// File: doc/BRIEF.md
# System Address Range Decoder

This block turns a physical address into a target socket, memory controller and channel. Each node has a table of range rules. The block scans that table one rule per clock until it finds an enabled rule whose window holds the address. The matching rule picks an interleave index from a fixed group of address bits. That index selects a 4-bit entry from the rule's target list.

A target entry points either at the local node or at a remote node. A remote entry restarts the scan once, in the table of the node whose identifier matches. A local entry yields a logical channel, taken either directly from the entry or from a modulo-3/modulo-2 computation on the address. A per-node route word then maps the logical channel to a controller number and a channel number.

Software loads every table through a simple register write port before issuing lookups. A lookup starts with a one-cycle start strobe and ends with a one-cycle done pulse. The result, or an error code, stays on the outputs until the next lookup completes.

Top module: `addrdec_top`

## Requirements
- R1: An address at or above the high-memory top, or at or above the low-memory top and below 2^32, finishes with error code 1 and no hit. This rejection comes 2 clocks after start is sampled.
- R2: Rules are scanned from index 0 upward. Rule i covers the addresses from the previous rule's limit plus one up to its own limit, and rule 0 starts at 0. The limit is rule bits 26:7 shifted left by 26 with the low 26 bits set. Only a rule with bit 0 set can match, but a disabled rule still moves the window start forward.
- R3: When none of the 24 rules of the current node matches, the lookup finishes with error code 2.
- R4: Rule bits 2:1 select the interleave index: 0 takes address bits 8:6, 1 takes 10:8, 2 takes 14:12, and 3 takes 32:30.
- R5: The index k selects bits 4k+3:4k of the rule's 32-bit target list. Entry bit 3 set means local. With rule bit 27 clear, the logical channel is entry bits 2:0.
- R6: An entry with bit 3 clear names node id = entry bits 2:0. The scan restarts at rule 0 of the node with that id, the lowest node index winning. The reported socket is the id of the node where the lookup ends.
- R7: A second remote entry in the same lookup gives error code 3. A remote id matching no node gives error code 4.
- R8: With rule bit 27 set, bits 31:30 choose a shift of 6, 8 or 12 (values 0, 1, 2). Bits 6:5 choose a base: 0 gives (addr>>shift) mod 3, 1 gives (addr>>shift) mod 2, and 3 gives ((addr>>shift) mod 2)<<1. The logical channel is {base[1:0], entry bit 0}.
- R9: With rule bit 27 set, a shift selector of 3 or a base selector of 2 gives error code 5.
- R10: On success (code 0, hit 1), the controller is route bits 3L+2:3L and the channel is route bits 2L+19:2L+18, for logical channel L. Route bits above 31 read as zero.
- R11: done is high for exactly one cycle per lookup. hit, code and fields are held unchanged while done is low. After reset, done, hit and code are 0.
- R12: A start strobe that arrives while a lookup is in progress is ignored.
- R13: One rule is examined per clock. A match at rule k with no redirect raises done k+3 clocks after start is sampled. A redirect adds the clocks spent scanning the second table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup of `addr` |
| addr | input | ADDR_W | Physical address to decode |
| cfgWe | input | 1 | Configuration write enable |
| cfgKind | input | 3 | Target: 0 rule, 1 target list, 2 route, 3 node id, 4 low top, 5 high top bits 31:0, 6 high top upper bits |
| cfgNode | input | NODE_W | Node selected by the write |
| cfgIdx | input | IDX_W | Rule index for kinds 0 and 1 |
| cfgData | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Lookup succeeded |
| errCode | output | 3 | 0 ok, 1 range, 2 no rule, 3 double remote, 4 unknown node, 5 bad modulo setting |
| socketId | output | 3 | Id of the resolving node |
| mcIdx | output | 3 | Memory controller number |
| chanIdx | output | 2 | Channel number |

## Verification
Two functions can meet in the same cycle: accepting a new start, and a scan or remote restart already in flight. The bench provokes this by raising start with a different address on the cycle right after a lookup has been accepted. This applies to both range rejections and multi-rule scans. The case passes only when the result and the latency equal those predicted for the first address alone, and no extra done pulse appears.

// File: rtl/addrdec_pkg.sv
package addrdec_pkg;
  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_RANGE  = 3'd1,
    ERR_NORULE = 3'd2,
    ERR_DOUBLE = 3'd3,
    ERR_NONODE = 3'd4,
    ERR_MODE   = 3'd5
  } err_e;

  typedef enum logic [2:0] {
    CFG_RULE  = 3'd0,
    CFG_TGT   = 3'd1,
    CFG_ROUTE = 3'd2,
    CFG_ID    = 3'd3,
    CFG_LOW   = 3'd4,
    CFG_HIGHL = 3'd5,
    CFG_HIGHU = 3'd6
  } cfg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic clrScan;
    logic advance;
    logic redirect;
    logic finish;
    err_e code;
  } ctl_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic rangeBad;
    logic ruleMatch;
    logic lastRule;
    logic isRemote;
    logic nodeFound;
    logic modBad;
  } stat_t;
endpackage

// File: rtl/addrdec_dp.sv
module addrdec_dp
  import addrdec_pkg::*;
#(
  parameter int ADDR_W = 46,
  parameter int NODES  = 2,
  parameter int RULES  = 24,
  parameter int NODE_W = 1,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfgWe,
  input  logic [2:0]        cfgKind,
  input  logic [NODE_W-1:0] cfgNode,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  ctl_t              ctl,
  output stat_t             stat,
  output logic              done,
  output logic              hit,
  output logic [2:0]        errCode,
  output logic [2:0]        socketId,
  output logic [2:0]        mcIdx,
  output logic [1:0]        chanIdx
);
  localparam int LOW_ONES = ADDR_W - 20;

  logic [31:0]       ruleMem [NODES][RULES];
  logic [31:0]       tgtMem  [NODES][RULES];
  logic [31:0]       routeMem[NODES];
  logic [2:0]        idMem   [NODES];
  logic [31:0]       lowTop;
  logic [ADDR_W-1:0] highTop;

  logic [ADDR_W-1:0] addrQ;
  logic [NODE_W-1:0] nodeQ;
  logic [IDX_W-1:0]  idxQ;
  logic [ADDR_W:0]   prevQ;

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < NODES; n++) begin
        for (int r = 0; r < RULES; r++) begin
          ruleMem[n][r] <= '0;
          tgtMem[n][r]  <= '0;
        end
        routeMem[n] <= '0;
        idMem[n]    <= '0;
      end
      lowTop  <= '0;
      highTop <= '0;
    end else if (cfgWe) begin
      case (cfg_e'(cfgKind))
        CFG_RULE:  if (int'(cfgIdx) < RULES) ruleMem[cfgNode][cfgIdx] <= cfgData;
        CFG_TGT:   if (int'(cfgIdx) < RULES) tgtMem[cfgNode][cfgIdx] <= cfgData;
        CFG_ROUTE: routeMem[cfgNode] <= cfgData;
        CFG_ID:    idMem[cfgNode] <= cfgData[2:0];
        CFG_LOW:   lowTop <= cfgData;
        CFG_HIGHL: highTop[31:0] <= cfgData;
        CFG_HIGHU: highTop[ADDR_W-1:32] <= cfgData[ADDR_W-33:0];
        default: ;
      endcase
    end
  end

  // current rule view
  logic [31:0]       curRule, curTgt, curRoute;
  logic [ADDR_W-1:0] limit;
  logic [2:0]        ilvIdx;
  logic [3:0]        tgt;

  assign curRule  = ruleMem[nodeQ][idxQ];
  assign curTgt   = tgtMem[nodeQ][idxQ];
  assign curRoute = routeMem[nodeQ];
  assign limit    = {curRule[26:7], {LOW_ONES{1'b1}}};

  always_comb begin
    case (curRule[2:1])
      2'd0:    ilvIdx = addrQ[8:6];
      2'd1:    ilvIdx = addrQ[10:8];
      2'd2:    ilvIdx = addrQ[14:12];
      default: ilvIdx = addrQ[32:30];
    endcase
  end

  assign tgt = curTgt[{ilvIdx, 2'b00} +: 4];

  // remote node lookup, lowest node index wins
  logic [NODES-1:0]  idHit;
  logic [NODE_W-1:0] matchNode;

  for (genvar n = 0; n < NODES; n++) begin : g_idcmp
    assign idHit[n] = (idMem[n] == tgt[2:0]);
  end

  always_comb begin
    matchNode = '0;
    for (int n = NODES - 1; n >= 0; n--)
      if (idHit[n]) matchNode = NODE_W'(n);
  end

  // logical channel
  logic [4:0]        shAmt;
  logic [ADDR_W-1:0] shifted, rem3;
  logic [1:0]        base;
  logic [2:0]        lch;
  logic [33:0]       routeExt;
  int                mcPos, chPos;

  always_comb begin
    case (curRule[31:30])
      2'd0:    shAmt = 5'd6;
      2'd1:    shAmt = 5'd8;
      default: shAmt = 5'd12;
    endcase
    shifted = addrQ >> shAmt;
    rem3    = shifted % ADDR_W'(3);
    case (curRule[6:5])
      2'd0:    base = rem3[1:0];
      2'd1:    base = {1'b0, shifted[0]};
      2'd3:    base = {shifted[0], 1'b0};
      default: base = 2'd0;
    endcase
    lch      = curRule[27] ? {base, tgt[0]} : tgt[2:0];
    routeExt = {2'b00, curRoute};
    mcPos    = 3 * int'(lch);
    chPos    = 2 * int'(lch) + 18;
  end

  assign stat.rangeBad  = (addrQ >= highTop) ||
                          ({{(64-ADDR_W){1'b0}}, addrQ} >= {32'd0, lowTop} &&
                           {{(64-ADDR_W){1'b0}}, addrQ} < 64'h1_0000_0000);
  assign stat.ruleMatch = curRule[0] && ({1'b0, addrQ} >= prevQ) && (addrQ <= limit);
  assign stat.lastRule  = (int'(idxQ) == RULES - 1);
  assign stat.isRemote  = !tgt[3];
  assign stat.nodeFound = |idHit;
  assign stat.modBad    = curRule[27] && (curRule[31:30] == 2'd3 || curRule[6:5] == 2'd2);

  // scan state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      nodeQ <= '0;
      idxQ  <= '0;
      prevQ <= '0;
    end else begin
      if (ctl.loadAddr) addrQ <= addr;
      if (ctl.clrScan) begin
        nodeQ <= '0;
        idxQ  <= '0;
        prevQ <= '0;
      end else if (ctl.redirect) begin
        nodeQ <= matchNode;
        idxQ  <= '0;
        prevQ <= '0;
      end else if (ctl.advance) begin
        idxQ  <= idxQ + 1'b1;
        prevQ <= {1'b0, limit} + 1'b1;
      end
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done     <= 1'b0;
      hit      <= 1'b0;
      errCode  <= '0;
      socketId <= '0;
      mcIdx    <= '0;
      chanIdx  <= '0;
    end else begin
      done <= ctl.finish;
      if (ctl.finish) begin
        hit     <= (ctl.code == ERR_NONE);
        errCode <= ctl.code;
        if (ctl.code == ERR_NONE) begin
          socketId <= idMem[nodeQ];
          mcIdx    <= routeExt[mcPos +: 3];
          chanIdx  <= routeExt[chPos +: 2];
        end else begin
          socketId <= '0;
          mcIdx    <= '0;
          chanIdx  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/addrdec_ctrl.sv
module addrdec_ctrl
  import addrdec_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  stat_t stat,
  output ctl_t  ctl
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_SCAN} state_e;

  state_e stateQ, stateD;
  logic   redirQ, redirD;

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    redirD = redirQ;
    case (stateQ)
      S_IDLE: if (start) begin
        ctl.loadAddr = 1'b1;
        redirD       = 1'b0;
        stateD       = S_CHECK;
      end
      S_CHECK: begin
        if (stat.rangeBad) begin
          ctl.finish = 1'b1;
          ctl.code   = ERR_RANGE;
          stateD     = S_IDLE;
        end else begin
          ctl.clrScan = 1'b1;
          stateD      = S_SCAN;
        end
      end
      S_SCAN: begin
        if (stat.ruleMatch) begin
          if (stat.isRemote) begin
            if (redirQ) begin
              ctl.finish = 1'b1;
              ctl.code   = ERR_DOUBLE;
            end else if (!stat.nodeFound) begin
              ctl.finish = 1'b1;
              ctl.code   = ERR_NONODE;
            end else begin
              ctl.redirect = 1'b1;
              redirD       = 1'b1;
            end
          end else begin
            ctl.finish = 1'b1;
            ctl.code   = stat.modBad ? ERR_MODE : ERR_NONE;
          end
        end else if (stat.lastRule) begin
          ctl.finish = 1'b1;
          ctl.code   = ERR_NORULE;
        end else begin
          ctl.advance = 1'b1;
        end
        if (ctl.finish) stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      redirQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      redirQ <= redirD;
    end
  end
endmodule

// File: rtl/addrdec_top.sv
module addrdec_top
  import addrdec_pkg::*;
#(
  parameter int ADDR_W = 46,
  parameter int NODES  = 2,
  parameter int RULES  = 24,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int IDX_W  = (RULES > 1) ? $clog2(RULES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfgWe,
  input  logic [2:0]        cfgKind,
  input  logic [NODE_W-1:0] cfgNode,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  output logic              done,
  output logic              hit,
  output logic [2:0]        errCode,
  output logic [2:0]        socketId,
  output logic [2:0]        mcIdx,
  output logic [1:0]        chanIdx
);
  ctl_t  ctl;
  stat_t stat;

  addrdec_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stat (stat),
    .ctl  (ctl)
  );

  addrdec_dp #(
    .ADDR_W(ADDR_W), .NODES(NODES), .RULES(RULES),
    .NODE_W(NODE_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .cfgWe   (cfgWe),
    .cfgKind (cfgKind),
    .cfgNode (cfgNode),
    .cfgIdx  (cfgIdx),
    .cfgData (cfgData),
    .ctl     (ctl),
    .stat    (stat),
    .done    (done),
    .hit     (hit),
    .errCode (errCode),
    .socketId(socketId),
    .mcIdx   (mcIdx),
    .chanIdx (chanIdx)
  );
endmodule

// File: rtl/addrdec_chk.sv
module addrdec_chk #(
  parameter int RULES = 24
) (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       done,
  input logic       hit,
  input logic [2:0] errCode,
  input logic [2:0] socketId,
  input logic [2:0] mcIdx,
  input logic [1:0] chanIdx
);
  localparam int MAX_LAT = 2 * RULES + 4;

  logic pendQ;
  int   latQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      latQ  <= 0;
    end else if (start && (!pendQ || done)) begin
      pendQ <= 1'b1;
      latQ  <= 0;
    end else if (done) begin
      pendQ <= 1'b0;
      latQ  <= 0;
    end else if (pendQ) begin
      latQ <= latQ + 1;
    end
  end

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: results are held between completions
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({hit, errCode, socketId, mcIdx, chanIdx}));

  // R12: every completion belongs to an accepted start
  a_r12_done_has_start: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pendQ);

  // R13: one rule per clock bounds the lookup time
  a_r13_bounded: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> latQ <= MAX_LAT);

  // R10: a hit never carries an error code
  a_r10_hit_clean: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> errCode == 3'd0);
endmodule

bind addrdec_top addrdec_chk #(.RULES(RULES)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .hit(hit),
  .errCode(errCode), .socketId(socketId), .mcIdx(mcIdx), .chanIdx(chanIdx)
);

// File: tb/addrdec_top_tb.sv
module addrdec_top_tb;
  localparam int ADDR_W = 46;
  localparam int NODES  = 2;
  localparam int RULES  = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgKind = '0;
  logic [0:0]  cfgNode = '0;
  logic [4:0]  cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic        done, hit;
  logic [2:0]  errCode, socketId, mcIdx;
  logic [1:0]  chanIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] rulesM[NODES][RULES];
  logic [31:0] tgtM[NODES][RULES];
  logic [31:0] routeM[NODES];
  logic [2:0]  idM[NODES];
  logic [63:0] loTop, hiTop;

  always #10 clk = ~clk;

  addrdec_top #(.ADDR_W(ADDR_W), .NODES(NODES), .RULES(RULES)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr),
    .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgNode(cfgNode), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .done(done), .hit(hit), .errCode(errCode),
    .socketId(socketId), .mcIdx(mcIdx), .chanIdx(chanIdx)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input int kind, input int node, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgKind = 3'(kind); cfgNode = 1'(node); cfgIdx = 5'(idx); cfgData = d;
    case (kind)
      0: rulesM[node][idx] = d;
      1: tgtM[node][idx] = d;
      2: routeM[node] = d;
      3: idM[node] = d[2:0];
      4: loTop = {32'd0, d};
      5: hiTop[31:0] = d;
      6: hiTop[63:32] = {18'd0, d[13:0]};
      default: ;
    endcase
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [31:0] mkRule(int field, bit en, int mode, bit m3, int m3mode, int sel);
    logic [31:0] r;
    r = '0;
    r[0] = en; r[2:1] = 2'(mode); r[6:5] = 2'(sel);
    r[26:7] = 20'(field); r[27] = m3; r[31:30] = 2'(m3mode);
    return r;
  endfunction

  // reference model from the requirements
  task automatic model(input logic [63:0] a, output int code, output int soc,
                       output int mc, output int ch, output int lat);
    int node, k, sh, b, l;
    bit redir, found;
    logic [63:0] prev, lim, s;
    logic [31:0] r;
    logic [3:0] nib;
    logic [2:0] ix;
    code = 0; soc = 0; mc = 0; ch = 0;
    if (a >= hiTop || (a >= loTop && a < 64'h1_0000_0000)) begin
      code = 1; lat = 2; return;
    end
    lat = 2; node = 0; redir = 0;
    forever begin
      prev = 0; found = 0; k = 0;
      for (int i = 0; i < RULES; i++) begin
        lat++;
        r = rulesM[node][i];
        lim = ({44'd0, r[26:7]} << 26) | 64'h3FF_FFFF;
        if (r[0] && a >= prev && a <= lim) begin found = 1; k = i; break; end
        prev = lim + 1;
      end
      if (!found) begin code = 2; return; end
      r = rulesM[node][k];
      case (r[2:1])
        2'd0: ix = a[8:6];
        2'd1: ix = a[10:8];
        2'd2: ix = a[14:12];
        default: ix = a[32:30];
      endcase
      nib = 4'(tgtM[node][k] >> (4 * ix));
      if (!nib[3]) begin
        int nn;
        if (redir) begin code = 3; return; end
        nn = -1;
        for (int n = NODES - 1; n >= 0; n--) if (idM[n] == nib[2:0]) nn = n;
        if (nn < 0) begin code = 4; return; end
        node = nn; redir = 1;
        continue;
      end
      if (!r[27]) l = int'(nib[2:0]);
      else begin
        if (r[31:30] == 2'd3 || r[6:5] == 2'd2) begin code = 5; return; end
        sh = (r[31:30] == 0) ? 6 : (r[31:30] == 1) ? 8 : 12;
        s = a >> sh;
        case (r[6:5])
          2'd0: b = int'(s % 3);
          2'd1: b = int'(s[0]);
          default: b = int'(s[0]) << 1;
        endcase
        l = (b << 1) | int'(nib[0]);
      end
      soc = int'(idM[node]);
      mc = int'(3'(routeM[node] >> (3 * l)));
      ch = int'(2'({32'd0, routeM[node]} >> (2 * l + 18)));
      return;
    end
  endtask

  function automatic string tagOf(int code);
    case (code)
      1: return "R1";
      2: return "R3";
      3, 4: return "R7";
      5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic runOne(input logic [63:0] a, input bit poke, input logic [63:0] pa, input string tag);
    int eCode, eSoc, eMc, eCh, eLat, cnt;
    model(a, eCode, eSoc, eMc, eCh, eLat);
    @(negedge clk);
    addr = a[ADDR_W-1:0]; start = 1'b1;
    @(posedge clk); cnt = 1;
    @(negedge clk);
    start = poke;
    if (poke) addr = pa[ADDR_W-1:0];
    while (!done && cnt < 200) begin
      @(posedge clk); cnt++;
      @(negedge clk); start = 1'b0;
    end
    check(tag, int'(errCode), eCode, "code");
    check(tag, int'(hit), int'(eCode == 0), "hit");
    check("R13", cnt, eLat, "latency");
    if (eCode == 0) begin
      check(tag, int'(socketId), eSoc, "socket");
      check(tag, int'(mcIdx), eMc, "controller");
      check(tag, int'(chanIdx), eCh, "channel");
    end
    @(negedge clk);
    check("R11", int'(done), 0, "done falls");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int n = 0; n < NODES; n++) begin
      for (int i = 0; i < RULES; i++) begin rulesM[n][i] = '0; tgtM[n][i] = '0; end
      routeM[n] = '0; idM[n] = '0;
    end
    loTop = 0; hiTop = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", int'(done), 0, "reset done");
    check("R11", int'(hit), 0, "reset hit");
    check("R11", int'(errCode), 0, "reset code");

    cfgWrite(3, 0, 0, 32'd3);
    cfgWrite(3, 1, 0, 32'd5);
    cfgWrite(4, 0, 0, 32'hC000_0000);
    cfgWrite(5, 0, 0, 32'h0);
    cfgWrite(6, 0, 0, 32'h18);
    for (int n = 0; n < NODES; n++) begin
      cfgWrite(2, n, 0, $urandom);
      for (int i = 0; i < RULES; i++) begin
        logic [31:0] t;
        for (int j = 0; j < 8; j++) begin
          int v;
          v = $urandom % 6;
          t[4*j +: 4] = (v == 0) ? 4'h5 : (v == 1) ? 4'h3 : (v == 2) ? 4'h7 : 4'(8 + $urandom % 8);
        end
        cfgWrite(0, n, i, mkRule((i + 1) * 64, ($urandom % 4) != 0, $urandom % 4,
                                 ($urandom % 3) == 0, $urandom % 4, $urandom % 4));
        cfgWrite(1, n, i, t);
      end
    end

    // random lookups (R2 R4 R5 R6 R8 R10 via model)
    for (int it = 0; it < 300; it++) begin
      logic [63:0] a;
      int c, s1, m1, h1, l1;
      a = {$urandom, $urandom} & ((it % 2) ? 64'h1F_FFFF_FFFF : 64'hBFFF_FFFF);
      model(a, c, s1, m1, h1, l1);
      runOne(a, 1'b0, 0, tagOf(c));
    end

    // R1 boundaries
    runOne(64'hC000_0000, 1'b0, 0, "R1");
    runOne(64'hFFFF_FFFF, 1'b0, 0, "R1");
    runOne(64'h18_0000_0000, 1'b0, 0, "R1");
    runOne(64'h17_FFFF_FFFF, 1'b0, 0, "R1");

    // R4 R5: direct local targets with all index modes
    cfgWrite(2, 0, 0, 32'hFEDC_BA98);
    cfgWrite(1, 0, 0, 32'hFEDC_BA98);
    for (int m = 0; m < 4; m++) begin
      cfgWrite(0, 0, 0, mkRule(64, 1, m, 0, 0, 0));
      runOne(64'h8000_5540 ^ (64'(m) << 7), 1'b0, 0, "R4");
    end
    // R10: logical channel 7 reads channel from bits above 31
    cfgWrite(1, 0, 0, 32'hFFFF_FFFF);
    runOne(64'h100, 1'b0, 0, "R10");

    // R8 modulo selections, R9 illegal settings
    cfgWrite(1, 0, 0, 32'h9999_9999);
    cfgWrite(0, 0, 0, mkRule(64, 1, 0, 1, 1, 0));
    runOne(64'h500, 1'b0, 0, "R8");
    cfgWrite(0, 0, 0, mkRule(64, 1, 0, 1, 2, 3));
    runOne(64'h3000, 1'b0, 0, "R8");
    cfgWrite(0, 0, 0, mkRule(64, 1, 0, 1, 0, 1));
    runOne(64'h40, 1'b0, 0, "R8");
    cfgWrite(0, 0, 0, mkRule(64, 1, 0, 1, 0, 2));
    runOne(64'h40, 1'b0, 0, "R9");
    cfgWrite(0, 0, 0, mkRule(64, 1, 0, 1, 3, 0));
    runOne(64'h40, 1'b0, 0, "R9");

    // R6 redirect, R7 failures
    cfgWrite(0, 0, 0, mkRule(64, 1, 0, 0, 0, 0));
    cfgWrite(1, 0, 0, 32'h5555_5555);
    cfgWrite(0, 1, 0, mkRule(64, 1, 0, 0, 0, 0));
    cfgWrite(1, 1, 0, 32'hAAAA_AAAA);
    runOne(64'h1234, 1'b0, 0, "R6");
    check("R6", int'(socketId), 5, "redirected socket");
    cfgWrite(1, 1, 0, 32'h3333_3333);
    runOne(64'h1234, 1'b0, 0, "R7");
    check("R7", int'(errCode), 3, "double remote");
    cfgWrite(1, 0, 0, 32'h7777_7777);
    runOne(64'h1234, 1'b0, 0, "R7");
    check("R7", int'(errCode), 4, "unknown node");

    // R2 disabled rule still advances window; R3 no match
    cfgWrite(1, 0, 0, 32'hAAAA_AAAA);
    cfgWrite(0, 0, 0, mkRule(64, 0, 0, 0, 0, 0));
    runOne(64'h1000, 1'b0, 0, "R2");
    check("R3", int'(errCode), 2, "no rule");

    // R12: start while busy is ignored
    cfgWrite(0, 0, 0, mkRule(64, 1, 0, 0, 0, 0));
    runOne(64'h1000, 1'b1, 64'hC800_0000, "R12");
    runOne(64'hD000_0000, 1'b1, 64'h40, "R12");
    runOne(64'h1_2345_6780, 1'b1, 64'h1000, "R12");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule